// File: doc/BRIEF.md
# eMMC PHY Power-Up Sequencer

This block brings an eMMC interface PHY back up in hardware each time the card clock is reprogrammed. A start strobe delivers the new target clock frequency in Hz. The block first decides whether a PHY power cycle is needed. A power cycle is needed only when the new clock differs from the one last requested and lies above the card-identification speed of 400 kHz. When it is not needed, the block records the new clock and signals completion straight away.

A power cycle has two parts. The power-off part drops calibration enable and then DLL enable. The power-on part prepares the I/O pads, waits for the pad calibration to settle, and turns calibration on. After a fixed wait it checks the calibration-done status a single time. If calibration succeeded, it drives a DLL frequency band chosen from the target clock, enables the DLL, and polls DLL-ready once per microsecond until a bounded limit.

All waits are counted in microsecond ticks produced from the system clock by a divider, and the number of system clocks per microsecond is a parameter. Both PHY status inputs pass through a two-flop synchroniser.

Top module: `phyup_seq`

## Requirements
- R1: A start is skipped when the requested frequency equals the stored clock or is at most 400000 Hz. A skipped start leaves every PHY control output unchanged, updates the stored clock, and raises done within two cycles of the strobe.
- R2: A power cycle first clears `cal_en_o`, and only in a later cycle clears `dll_en_o`.
- R3: Pad setup drives `pad_cfg_o` to 0, then sets `pad_en_o` to 1 and `drive_o` to 4. All three hold these values when `cal_en_o` rises.
- R4: `cal_en_o` rises no earlier than 3 microseconds (3·CLKS_PER_US clocks) after the start strobe.
- R5: Calibration-done is sampled once, 5 microseconds after `cal_en_o` rises. If it is low, `cal_err_o` is set, `dll_en_o` is never raised, and the sequence ends.
- R6: The band code on `band_o` is 1 below 75 MHz, 2 from 75 MHz up to below 125 MHz, 3 from 125 MHz up to below 175 MHz, and 0 at 175 MHz and above.
- R7: `band_o` already carries the code for the new frequency in the cycle before `dll_en_o` rises.
- R8: After `dll_en_o` rises, DLL-ready is checked once per microsecond. If it is seen, the sequence ends with no error. If DLL_LIMIT_US ticks pass without it, `dll_tmo_o` is set.
- R9: A start strobe that arrives while `busy_o` is high is ignored. It changes neither the stored clock nor the band code.
- R10: `done_o` is a single-cycle pulse at the end of every sequence, including skipped and aborted ones. `cal_err_o` and `dll_tmo_o` hold their values until the next accepted start, which clears them.
- R11: After reset, all outputs are 0 and the stored clock is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start strobe, one cycle |
| freq_hz_i | input | 32 | Target card clock in Hz, latched on start |
| cal_done_i | input | 1 | PHY calibration-done status (asynchronous) |
| dll_ready_i | input | 1 | PHY DLL-ready status (asynchronous) |
| pad_cfg_o | output | 3 | Pad configuration field |
| pad_en_o | output | 1 | Pad power/enable |
| drive_o | output | 4 | Pad drive setting |
| cal_en_o | output | 1 | Calibration enable |
| band_o | output | 2 | DLL frequency band code |
| dll_en_o | output | 1 | DLL enable |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | End-of-sequence pulse |
| cal_err_o | output | 1 | Calibration-done was low when sampled |
| dll_tmo_o | output | 1 | DLL-ready not seen within the limit |

## Verification
The bench aims at the skip rule's edges: exactly 400000 Hz, 400001 Hz, and a repeated frequency. A design that compared with the wrong inequality, or that did not store the clock, would cycle the PHY when it should not, or fail to cycle it when it should. It drives every band threshold on both sides, so an off-by-one boundary would show as a wrong band code just before DLL enable. It also covers a failed calibration, a DLL that never locks, and a start arriving mid-sequence. A faulty design would then enable the DLL after a failed calibration, end the poll early, or let the late start overwrite the latched frequency, which would show up later as a wrongly skipped or wrongly cycled start.

// File: rtl/phyup_pkg.sv
// Package: shared state encoding and fixed constants of the PHY power-up sequencer.
// Assumes: frequencies are unsigned 32-bit values in Hz.
package phyup_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_OFF_CAL,
        ST_OFF_DLL,
        ST_PAD_CLR,
        ST_PAD_SET,
        ST_SETTLE,
        ST_CAL_ON,
        ST_CAL_WAIT,
        ST_BAND,
        ST_DLL_ON,
        ST_POLL,
        ST_FINISH
    } seq_state_e;

    localparam logic [3:0] DRIVE_SETTING = 4'd4;
    localparam logic [2:0] PAD_CFG_CLEAR = 3'd0;

    localparam logic [31:0] BAND_EDGE_A_HZ = 32'd75_000_000;
    localparam logic [31:0] BAND_EDGE_B_HZ = 32'd125_000_000;
    localparam logic [31:0] BAND_EDGE_C_HZ = 32'd175_000_000;

    localparam logic [1:0] BAND_TOP = 2'd0;
    localparam logic [1:0] BAND_LOW = 2'd1;
    localparam logic [1:0] BAND_MID = 2'd2;
    localparam logic [1:0] BAND_UPR = 2'd3;

endpackage

// File: rtl/phyup_tick.sv
// Module: microsecond tick generator.
// Produces a one-cycle tick every CLKS_PER_US system clocks. A synchronous
// clear restarts the count so that a wait beginning with the clear sees its
// first tick exactly CLKS_PER_US clocks later.
// Assumes: CLKS_PER_US >= 2.
module phyup_tick #(
    parameter int CLKS_PER_US = 250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    output logic tick_o
);
    localparam int DIV_W = (CLKS_PER_US > 2) ? $clog2(CLKS_PER_US) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLKS_PER_US - 1);

    logic [DIV_W-1:0] div_q;

    // Tick on the last count of the divider period.
    assign tick_o = (div_q == DIV_LAST);

    // Divider counter, wrapping each period and restarted by clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i || tick_o) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end
endmodule

// File: rtl/phyup_sync.sv
// Module: per-bit two-flop synchroniser for asynchronous PHY status levels.
// Assumes: the inputs are slow levels, so no pulse capture is needed.
module phyup_sync #(
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic meta_q;
        logic stab_q;

        // Two back-to-back flops per status bit.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                stab_q <= 1'b0;
            end else begin
                meta_q <= async_i[b];
                stab_q <= meta_q;
            end
        end

        assign sync_o[b] = stab_q;
    end
endmodule

// File: rtl/phyup_band.sv
// Module: DLL band encoder.
// Maps a target clock frequency in Hz to the 2-bit DLL band code.
// Assumes: thresholds come from phyup_pkg, and comparisons are unsigned.
module phyup_band #(
    parameter int FREQ_W = 32
) (
    input  logic [FREQ_W-1:0] freq_i,
    output logic [1:0]        band_o
);
    import phyup_pkg::*;

    localparam logic [FREQ_W-1:0] EDGE_A = FREQ_W'(BAND_EDGE_A_HZ);
    localparam logic [FREQ_W-1:0] EDGE_B = FREQ_W'(BAND_EDGE_B_HZ);
    localparam logic [FREQ_W-1:0] EDGE_C = FREQ_W'(BAND_EDGE_C_HZ);

    // Priority comparison from the lowest threshold upward.
    always_comb begin
        if (freq_i < EDGE_A) begin
            band_o = BAND_LOW;
        end else if (freq_i < EDGE_B) begin
            band_o = BAND_MID;
        end else if (freq_i < EDGE_C) begin
            band_o = BAND_UPR;
        end else begin
            band_o = BAND_TOP;
        end
    end
endmodule

// File: rtl/phyup_seq.sv
// Module: eMMC PHY power-up sequencer (top).
// On a start strobe, decides whether the PHY needs a power cycle. If it does,
// it runs power-off, pad setup, a settle wait, calibration with one check,
// band selection, DLL enable and a bounded once-per-microsecond DLL poll.
// Assumes: start_i is a one-cycle strobe. PHY status inputs are asynchronous.
// Each wait restarts the tick divider when its state is entered.
module phyup_seq #(
    parameter int          CLKS_PER_US  = 250,
    parameter int          SETTLE_US    = 3,
    parameter int          CAL_WAIT_US  = 5,
    parameter int          DLL_LIMIT_US = 50000,
    parameter int          FREQ_W       = 32,
    parameter logic [31:0] ID_FREQ_HZ   = 32'd400_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [FREQ_W-1:0] freq_hz_i,
    input  logic              cal_done_i,
    input  logic              dll_ready_i,
    output logic [2:0]        pad_cfg_o,
    output logic              pad_en_o,
    output logic [3:0]        drive_o,
    output logic              cal_en_o,
    output logic [1:0]        band_o,
    output logic              dll_en_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              cal_err_o,
    output logic              dll_tmo_o
);
    import phyup_pkg::*;

    localparam int CNT_MAX_A = (SETTLE_US > CAL_WAIT_US) ? SETTLE_US : CAL_WAIT_US;
    localparam int CNT_MAX   = (CNT_MAX_A > DLL_LIMIT_US) ? CNT_MAX_A : DLL_LIMIT_US;
    localparam int CNT_W     = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(SETTLE_US - 1);
    localparam logic [CNT_W-1:0] CALW_LAST   = CNT_W'(CAL_WAIT_US - 1);
    localparam logic [CNT_W-1:0] LIMIT_LAST  = CNT_W'(DLL_LIMIT_US - 1);
    localparam logic [FREQ_W-1:0] ID_FREQ    = FREQ_W'(ID_FREQ_HZ);

    seq_state_e        state_q, state_d;
    logic [CNT_W-1:0]  us_cnt_q;
    logic [FREQ_W-1:0] cur_clk_q;
    logic [FREQ_W-1:0] tgt_clk_q;
    logic              tick;
    logic              tick_clr;
    logic [1:0]        stat_sync;
    logic              cal_ok_s;
    logic              dll_rdy_s;
    logic [1:0]        band_code;
    logic              need_cycle;

    // Restart the microsecond divider on every state change.
    assign tick_clr = (state_d != state_q);

    phyup_tick #(
        .CLKS_PER_US (CLKS_PER_US)
    ) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (tick_clr),
        .tick_o (tick)
    );

    phyup_sync #(
        .WIDTH (2)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({dll_ready_i, cal_done_i}),
        .sync_o  (stat_sync)
    );

    assign cal_ok_s  = stat_sync[0];
    assign dll_rdy_s = stat_sync[1];

    phyup_band #(
        .FREQ_W (FREQ_W)
    ) u_band (
        .freq_i (tgt_clk_q),
        .band_o (band_code)
    );

    // Power cycle only for a changed clock above identification speed.
    assign need_cycle = (freq_hz_i != cur_clk_q) && (freq_hz_i > ID_FREQ);

    // Next-state selection for the ordered bring-up.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (start_i) state_d = need_cycle ? ST_OFF_CAL : ST_FINISH;
            ST_OFF_CAL:  state_d = ST_OFF_DLL;
            ST_OFF_DLL:  state_d = ST_PAD_CLR;
            ST_PAD_CLR:  state_d = ST_PAD_SET;
            ST_PAD_SET:  state_d = ST_SETTLE;
            ST_SETTLE:   if (tick && us_cnt_q == SETTLE_LAST) state_d = ST_CAL_ON;
            ST_CAL_ON:   state_d = ST_CAL_WAIT;
            ST_CAL_WAIT: if (tick && us_cnt_q == CALW_LAST) state_d = cal_ok_s ? ST_BAND : ST_FINISH;
            ST_BAND:     state_d = ST_DLL_ON;
            ST_DLL_ON:   state_d = ST_POLL;
            ST_POLL:     if (tick && (dll_rdy_s || us_cnt_q == LIMIT_LAST)) state_d = ST_FINISH;
            ST_FINISH:   state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // State register and per-state microsecond counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            us_cnt_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_d != state_q) begin
                us_cnt_q <= '0;
            end else if (tick) begin
                us_cnt_q <= us_cnt_q + 1'b1;
            end
        end
    end

    // Clock bookkeeping: latch the target and store it on every accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_clk_q <= '0;
            tgt_clk_q <= '0;
        end else if (state_q == ST_IDLE && start_i) begin
            cur_clk_q <= freq_hz_i;
            tgt_clk_q <= freq_hz_i;
        end
    end

    // PHY control outputs, each changed by exactly one step of the sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pad_cfg_o <= '0;
            pad_en_o  <= 1'b0;
            drive_o   <= '0;
            cal_en_o  <= 1'b0;
            band_o    <= '0;
            dll_en_o  <= 1'b0;
        end else begin
            unique case (state_q)
                ST_OFF_CAL: cal_en_o  <= 1'b0;
                ST_OFF_DLL: dll_en_o  <= 1'b0;
                ST_PAD_CLR: pad_cfg_o <= PAD_CFG_CLEAR;
                ST_PAD_SET: begin
                    pad_en_o <= 1'b1;
                    drive_o  <= DRIVE_SETTING;
                end
                ST_CAL_ON:  cal_en_o  <= 1'b1;
                ST_BAND:    band_o    <= band_code;
                ST_DLL_ON:  dll_en_o  <= 1'b1;
                default:    ;
            endcase
        end
    end

    // Error flags: cleared by an accepted start, set by the failing step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cal_err_o <= 1'b0;
            dll_tmo_o <= 1'b0;
        end else if (state_q == ST_IDLE && start_i) begin
            cal_err_o <= 1'b0;
            dll_tmo_o <= 1'b0;
        end else if (state_q == ST_CAL_WAIT && tick && us_cnt_q == CALW_LAST && !cal_ok_s) begin
            cal_err_o <= 1'b1;
        end else if (state_q == ST_POLL && tick && !dll_rdy_s && us_cnt_q == LIMIT_LAST) begin
            dll_tmo_o <= 1'b1;
        end
    end

    // Status decode from the registered state.
    assign busy_o = (state_q != ST_IDLE);
    assign done_o = (state_q == ST_FINISH);

endmodule

// File: rtl/phyup_chk.sv
// Module: property checker for phyup_seq, attached by bind.
// Assumes: it observes top-level ports only.
module phyup_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] pad_cfg_o,
    input logic       pad_en_o,
    input logic [3:0] drive_o,
    input logic       cal_en_o,
    input logic [1:0] band_o,
    input logic       dll_en_o,
    input logic       busy_o,
    input logic       start_i,
    input logic       done_o,
    input logic       cal_err_o,
    input logic       dll_tmo_o
);
    // R2
    off_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dll_en_o) |-> !cal_en_o);

    // R3
    pad_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cal_en_o) |-> (pad_en_o && drive_o == 4'd4 && pad_cfg_o == 3'd0));

    // R5
    no_dll_after_calerr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cal_err_o |-> !dll_en_o);

    // R7
    band_before_dll_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dll_en_o) |-> ($stable(band_o) && cal_en_o));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R10
    single_error_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cal_err_o && dll_tmo_o));

    // R9
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o && start_i) |=> busy_o);
endmodule

bind phyup_seq phyup_chk u_phyup_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pad_cfg_o (pad_cfg_o),
    .pad_en_o  (pad_en_o),
    .drive_o   (drive_o),
    .cal_en_o  (cal_en_o),
    .band_o    (band_o),
    .dll_en_o  (dll_en_o),
    .busy_o    (busy_o),
    .start_i   (start_i),
    .done_o    (done_o),
    .cal_err_o (cal_err_o),
    .dll_tmo_o (dll_tmo_o)
);

// File: tb/test_phyup_seq.sv
// Bench: directed corner cases plus seeded random sequences for phyup_seq.
module test_phyup_seq;
    localparam int CPU = 4;
    localparam int TMO = 30;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] freq_hz_i = '0;
    logic        cal_done_i = 1'b0;
    logic        dll_ready_i = 1'b0;
    logic [2:0]  pad_cfg_o;
    logic        pad_en_o;
    logic [3:0]  drive_o;
    logic        cal_en_o;
    logic [1:0]  band_o;
    logic        dll_en_o;
    logic        busy_o;
    logic        done_o;
    logic        cal_err_o;
    logic        dll_tmo_o;

    int          cyc = 0;
    int          n_chk = 0;
    int          n_fail = 0;
    logic [31:0] model_clk = '0;

    always #2 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    phyup_seq #(
        .CLKS_PER_US  (CPU),
        .DLL_LIMIT_US (TMO)
    ) i_phyup_seq (
        .clk (clk), .rst_n (rst_n), .start_i (start_i), .freq_hz_i (freq_hz_i),
        .cal_done_i (cal_done_i), .dll_ready_i (dll_ready_i),
        .pad_cfg_o (pad_cfg_o), .pad_en_o (pad_en_o), .drive_o (drive_o),
        .cal_en_o (cal_en_o), .band_o (band_o), .dll_en_o (dll_en_o),
        .busy_o (busy_o), .done_o (done_o), .cal_err_o (cal_err_o),
        .dll_tmo_o (dll_tmo_o)
    );

    // Record one check and report a failure with actual and expected values.
    task automatic check(input string req, input bit ok, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Band code expected from the frequency thresholds.
    function automatic logic [1:0] exp_band(input logic [31:0] f);
        if (f < 32'd75_000_000) return 2'd1;
        if (f < 32'd125_000_000) return 2'd2;
        if (f < 32'd175_000_000) return 2'd3;
        return 2'd0;
    endfunction

    // Run one start and check the whole sequence; rdy_us < 0 means never ready.
    task automatic run_seq(input logic [31:0] f, input bit cal_ok, input int rdy_us,
                           input logic [31:0] inj);
        bit         skip_exp;
        int         t0, tcal_f, tdll_f, tcal_r, tdll_r, tdone;
        logic       pcal, pdll, was_dll, was_cal, pad_ok;
        logic [1:0] pband, band_pre;
        logic       e_cal, e_tmo;
        skip_exp = (f == model_clk) || (f <= 32'd400_000);
        model_clk = f;
        tcal_f = -1; tdll_f = -1; tcal_r = -1; tdll_r = -1; tdone = -1;
        pad_ok = 1'b0; band_pre = 2'bxx;
        @(negedge clk);
        cal_done_i = cal_ok; dll_ready_i = 1'b0;
        start_i = 1'b1; freq_hz_i = f;
        was_dll = dll_en_o; was_cal = cal_en_o;
        pcal = cal_en_o; pdll = dll_en_o; pband = band_o;
        @(negedge clk);
        start_i = 1'b0;
        t0 = cyc;
        for (int k = 0; k < 4000 && tdone < 0; k++) begin
            if (pcal && !cal_en_o && tcal_f < 0) tcal_f = cyc;
            if (pdll && !dll_en_o && tdll_f < 0) tdll_f = cyc;
            if (!pcal && cal_en_o && tcal_r < 0) begin
                tcal_r = cyc;
                pad_ok = pad_en_o && drive_o == 4'd4 && pad_cfg_o == 3'd0;
            end
            if (!pdll && dll_en_o && tdll_r < 0) begin
                tdll_r = cyc;
                band_pre = pband;
            end
            if (tdll_r >= 0 && rdy_us >= 0 && cyc - tdll_r >= rdy_us * CPU) dll_ready_i = 1'b1;
            if (done_o) tdone = cyc;
            pcal = cal_en_o; pdll = dll_en_o; pband = band_o;
            if (k == 5 && inj != 0) begin start_i = 1'b1; freq_hz_i = inj; end
            if (k == 6) start_i = 1'b0;
            @(negedge clk);
        end
        check("R10 done seen", tdone >= 0, tdone, 0);
        check("R10 done one cycle", done_o == 1'b0, done_o, 0);
        if (skip_exp) begin
            check("R1 skip fast done", tdone - t0 <= 2, tdone - t0, 2);
            check("R1 skip no PHY change",
                  tcal_r < 0 && tdll_r < 0 && tcal_f < 0 && tdll_f < 0,
                  tcal_r + tdll_r + tcal_f + tdll_f, -4);
            e_cal = 1'b0; e_tmo = 1'b0;
        end else begin
            if (was_cal) check("R2 cal_en cleared", tcal_f >= 0, tcal_f, 0);
            if (was_dll) check("R2 dll_en cleared after cal_en",
                               tdll_f > tcal_f && tcal_f >= 0, tdll_f, tcal_f + 1);
            check("R3 pad setup at cal_en", tcal_r >= 0 && pad_ok, pad_ok, 1);
            check("R4 settle wait", tcal_r - t0 >= 3 * CPU, tcal_r - t0, 3 * CPU);
            if (!cal_ok) begin
                check("R5 no dll_en after cal fail", tdll_r < 0, tdll_r, -1);
                check("R5 cal wait", tdone - tcal_r >= 5 * CPU, tdone - tcal_r, 5 * CPU);
            end else begin
                check("R5 cal wait before band", tdll_r - tcal_r >= 5 * CPU, tdll_r - tcal_r, 5 * CPU);
                check("R6 R7 band before dll_en", band_pre == exp_band(f), band_pre, exp_band(f));
                if (rdy_us < 0) begin
                    check("R8 poll limit", tdone - tdll_r >= TMO * CPU, tdone - tdll_r, TMO * CPU);
                end else begin
                    check("R8 poll stops on ready",
                          tdone - tdll_r >= rdy_us * CPU && tdone - tdll_r <= (rdy_us + 1) * CPU + 4,
                          tdone - tdll_r, (rdy_us + 1) * CPU);
                end
            end
            e_cal = !cal_ok;
            e_tmo = cal_ok && rdy_us < 0;
        end
        check("R5 cal_err flag", cal_err_o == e_cal, cal_err_o, e_cal);
        check("R8 dll_tmo flag", dll_tmo_o == e_tmo, dll_tmo_o, e_tmo);
        repeat (8) @(negedge clk);
        check("R10 flags held", cal_err_o == e_cal && dll_tmo_o == e_tmo,
              {cal_err_o, dll_tmo_o}, {e_cal, e_tmo});
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] f;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 reset outputs",
              {pad_cfg_o, pad_en_o, drive_o, cal_en_o, band_o, dll_en_o,
               busy_o, done_o, cal_err_o, dll_tmo_o} == '0,
              {pad_cfg_o, pad_en_o, drive_o, cal_en_o, band_o, dll_en_o}, 0);

        run_seq(32'd50_000_000, 1'b1, 3, 0);
        run_seq(32'd50_000_000, 1'b1, 3, 0);          // R1 repeat
        run_seq(32'd400_000, 1'b1, 3, 0);             // R1 boundary
        run_seq(32'd400_001, 1'b1, 2, 0);             // R1 just above
        run_seq(32'd74_999_999, 1'b1, 1, 0);          // R6 edges
        run_seq(32'd75_000_000, 1'b1, 0, 0);
        run_seq(32'd124_999_999, 1'b1, 4, 0);
        run_seq(32'd125_000_000, 1'b1, 4, 0);
        run_seq(32'd174_999_999, 1'b1, 5, 0);
        run_seq(32'd175_000_000, 1'b1, 5, 0);
        run_seq(32'd100_000_000, 1'b0, 3, 0);         // R5 failure
        run_seq(32'd150_000_000, 1'b1, -1, 0);        // R8 timeout
        run_seq(32'd60_000_000, 1'b1, 2, 32'd200_000_000); // R9 late start
        run_seq(32'd60_000_000, 1'b1, 2, 0);          // R9 stored clock intact

        for (int i = 0; i < 14; i++) begin
            case ($urandom % 4)
                0: f = model_clk;
                1: f = $urandom_range(0, 400_000);
                default: f = $urandom_range(400_001, 250_000_000);
            endcase
            run_seq(f, ($urandom % 4) != 0,
                    (($urandom % 5) == 0) ? -1 : int'($urandom_range(0, TMO - 8)), 0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule